// File: doc/BRIEF.md
# Byte-Wise SEC-DED Protected SRAM Core

This core is a small synchronous memory whose access interface follows an asynchronous SRAM: an active-low chip select, an active-low write enable, an active-low output enable, an address bus, and a byte-wide data bus. The data bus is split into an input bus, an output bus and an output-valid signal, which stands in for a three-state pad. Each stored byte carries its own five check bits. The check bits are computed on every write. On every read the stored 13-bit word is checked, a single flipped bit is repaired, and two status flags report what the check found. The flags follow the same timing and enable rules as the read data.

After reset the core reports busy for a fixed number of clock cycles, set by a parameter, and ignores all accesses during that time. A test-only port XORs a mask into one stored 13-bit word. The bench uses it to plant one-bit and two-bit faults. The repaired value is only returned on the bus and is never written back, so a planted fault stays in the array until the location is written again.

Top module: `ecc_byte_sram`

## Requirements
- R1: After reset, `busy` is 1 for exactly INIT_CYCLES rising clock edges and then stays 0. While `busy` is 1, writes leave the array unchanged and reads leave `q_en` at 0.
- R2: A read (`cs_n`=0, `we_n`=1, `oe_n`=0) sampled at one rising edge drives `q_en`=1, the stored byte on `dout`, and `err_fixed`=0 and `err_fatal`=0 after that edge, when the word has no fault.
- R3: The stored word is 13 bits. Bit 0 is an overall parity bit. Bits 1..12 form a Hamming word with check bits at positions 1, 2, 4 and 8, and data bits d0..d7 at positions 3, 5, 6, 7, 9, 10, 11 and 12. When any one data position is flipped, a read returns the original byte with `err_fixed`=1 and `err_fatal`=0.
- R4: When only a check bit is flipped (position 0, 1, 2, 4 or 8), a read returns the unchanged byte with `err_fixed`=1 and `err_fatal`=0.
- R5: When any two bits of a stored word are flipped, a read reports `err_fixed`=0 and `err_fatal`=1, and the returned byte must be treated as invalid.
- R6: With `cs_n`=1 at a rising edge, `q_en`, `dout`, `err_fixed` and `err_fatal` are all 0 after that edge.
- R7: With `cs_n`=0 and `we_n`=0 at a rising edge, the byte on `din` is stored at `addr`, and the outputs are all 0 after that edge even when `oe_n`=0.
- R8: A read with `oe_n`=1 leaves `q_en`, `dout` and both flags at 0.
- R9: A repair is not written back. Reading a word with one flipped bit again reports `err_fixed`=1 again.
- R10: When `inj_en`=1 at a rising edge, `inj_mask` is XORed into the stored word at `inj_addr`. A write to the same word in the same cycle takes priority over the mask.
- R11: While `rst_n` is 0, `busy` is 1 and `q_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | 8 | Write data byte |
| inj_en | input | 1 | Test-only fault injection strobe |
| inj_addr | input | ADDR_W | Word that receives the fault mask |
| inj_mask | input | 13 | Bits of the stored word to flip |
| busy | output | 1 | Initialization in progress; accesses are ignored |
| q_en | output | 1 | Output drive valid (models the bus leaving high impedance) |
| dout | output | 8 | Read data byte, 0 when not driven |
| err_fixed | output | 1 | One-bit error was corrected |
| err_fatal | output | 1 | Uncorrectable multi-bit error |

## Verification
The bench first tests the decoder against fault masks of weight zero, one and two, with the flipped bits placed in different parts of the word. A weight-one mask on a data position shows that the repair flips the right bit. A weight-one mask on a check position or on the overall parity bit shows that the byte is left alone but the event is still reported. Weight-two masks pair two check bits, a data bit with the parity bit, and a check bit with a data bit, which shows that every pair is reported as fatal and none is mistaken for a repair. Directed cases then cover the busy window, deselect, writes with output enable held low, reads with output enable high, and a repeated read of a faulty word.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
  localparam int DATA_W = 8;
  localparam int HAM_W  = 12;
  localparam int CW_W   = HAM_W + 1;

  typedef logic [CW_W-1:0]   cw_t;
  typedef logic [DATA_W-1:0] byte_t;

  typedef struct packed {
    byte_t data;
    logic  fixed;
    logic  fatal;
  } dec_t;

  function automatic logic is_check_pos(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Place data bits into the non-power-of-two Hamming positions.
  function automatic cw_t ecc_encode(input byte_t d);
    cw_t c;
    int  k;
    logic b;
    c = '0;
    k = 0;
    for (int p = 1; p <= HAM_W; p++) begin
      if (!is_check_pos(p)) begin
        c[p] = d[k];
        k++;
      end
    end
    for (int j = 0; j < 4; j++) begin
      b = 1'b0;
      for (int p = 1; p <= HAM_W; p++)
        if (((p >> j) & 1) == 1 && p != (1 << j)) b ^= c[p];
      c[1 << j] = b;
    end
    c[0] = ^c[HAM_W:1];
    return c;
  endfunction

  function automatic logic [3:0] ecc_syndrome(input cw_t c);
    logic [3:0] s;
    s = '0;
    for (int p = 1; p <= HAM_W; p++)
      if (c[p]) s ^= 4'(p);
    return s;
  endfunction

  function automatic dec_t ecc_decode(input cw_t c);
    dec_t       r;
    cw_t        f;
    logic [3:0] s;
    logic       par;
    int         k;
    s   = ecc_syndrome(c);
    par = ^c;
    f   = c;
    r.fixed = 1'b0;
    r.fatal = 1'b0;
    if (par) begin
      if (s == 4'd0) begin
        r.fixed = 1'b1;              // overall parity bit alone
      end else if (int'(s) <= HAM_W) begin
        f[s]    = ~f[s];
        r.fixed = 1'b1;
      end else begin
        r.fatal = 1'b1;              // odd weight, impossible position
      end
    end else if (s != 4'd0) begin
      r.fatal = 1'b1;
    end
    k = 0;
    r.data = '0;
    for (int p = 1; p <= HAM_W; p++) begin
      if (!is_check_pos(p)) begin
        r.data[k] = f[p];
        k++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_sram_init.sv
module ecc_sram_init #(
  parameter int INIT_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 2);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(INIT_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign busy = (cnt != LIMIT);
endmodule

// File: rtl/ecc_sram_array.sv
module ecc_sram_array
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  cw_t               wr_code,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  cw_t               inj_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output cw_t               rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  cw_t mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic hit_wr, hit_inj;
    assign hit_wr  = wr_en  && (wr_addr  == ADDR_W'(i));
    assign hit_inj = inj_en && (inj_addr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem[i] <= '0;
      else if (hit_wr)  mem[i] <= wr_code;
      else if (hit_inj) mem[i] <= mem[i] ^ inj_mask;
    end
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/ecc_sram_decoder.sv
module ecc_sram_decoder
  import ecc_sram_pkg::*;
(
  input  cw_t   word,
  output byte_t data,
  output logic  fixed,
  output logic  fatal
);
  dec_t r;
  assign r     = ecc_decode(word);
  assign data  = r.data;
  assign fixed = r.fixed;
  assign fatal = r.fatal;
endmodule

// File: rtl/ecc_byte_sram.sv
module ecc_byte_sram
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int INIT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [12:0]       inj_mask,
  output logic              busy,
  output logic              q_en,
  output logic [7:0]        dout,
  output logic              err_fixed,
  output logic              err_fatal
);
  // Named internal events, observed by the bound checker.
  logic  wr_fire, rd_fire, rd_drive;
  cw_t   rd_word;
  byte_t dec_data;
  logic  dec_fixed, dec_fatal;

  ecc_sram_init #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk(clk), .rst_n(rst_n), .busy(busy)
  );

  assign wr_fire  = !busy && !cs_n && !we_n;
  assign rd_fire  = !busy && !cs_n &&  we_n;
  assign rd_drive = rd_fire && !oe_n;

  ecc_sram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_fire), .wr_addr(addr), .wr_code(ecc_encode(din)),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask),
    .rd_addr(addr), .rd_word(rd_word)
  );

  ecc_sram_decoder u_dec (
    .word(rd_word), .data(dec_data), .fixed(dec_fixed), .fatal(dec_fatal)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_en      <= 1'b0;
      dout      <= '0;
      err_fixed <= 1'b0;
      err_fatal <= 1'b0;
    end else if (rd_drive) begin
      q_en      <= 1'b1;
      dout      <= dec_data;
      err_fixed <= dec_fixed;
      err_fatal <= dec_fatal;
    end else begin
      q_en      <= 1'b0;
      dout      <= '0;
      err_fixed <= 1'b0;
      err_fatal <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_byte_sram_chk.sv
module ecc_byte_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       we_n,
  input logic       oe_n,
  input logic       busy,
  input logic       q_en,
  input logic [7:0] dout,
  input logic       err_fixed,
  input logic       err_fatal,
  input logic       rd_fire,
  input logic       dec_fixed,
  input logic       dec_fatal
);
  // R3/R5: the decoder never reports both outcomes for one word.
  p_dec_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_fixed && dec_fatal));

  p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_fixed && err_fatal));

  p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !q_en |-> (dout == 8'h00 && !err_fixed && !err_fatal));

  p_busy_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !q_en);

  p_busy_stays_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);

  p_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !q_en);

  p_write_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |=> !q_en);

  p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !q_en);

  p_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !oe_n) |=> q_en);
endmodule

bind ecc_byte_sram ecc_byte_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
  .busy(busy), .q_en(q_en), .dout(dout),
  .err_fixed(err_fixed), .err_fatal(err_fatal),
  .rd_fire(rd_fire), .dec_fixed(dec_fixed), .dec_fatal(dec_fatal)
);

// File: tb/tb_ecc_byte_sram.sv
`timescale 1ns/1ps
module tb_ecc_byte_sram;
  localparam int AW    = 4;
  localparam int INITC = 20;
  localparam int NV    = 11;

  // Entry: {addr[4], data[8], mask[13]}. Flag expectation comes from mask weight.
  localparam logic [24:0] VEC [NV] = '{
    {4'h0, 8'hA5, 13'h0000},   // clean
    {4'h1, 8'h3C, 13'h0008},   // d0 at position 3
    {4'h2, 8'hFF, 13'h1000},   // d7 at position 12
    {4'h3, 8'h00, 13'h0001},   // overall parity bit only
    {4'h4, 8'h81, 13'h0010},   // check position 4
    {4'h5, 8'h5A, 13'h0006},   // check positions 1 and 2
    {4'h6, 8'hC3, 13'h1001},   // d7 plus overall parity
    {4'h7, 8'h7E, 13'h0300},   // check 8 plus data 9
    {4'hF, 8'h96, 13'h0100},   // check position 8
    {4'h8, 8'h24, 13'h0040},   // data at position 6
    {4'h9, 8'hE1, 13'h0000}    // clean
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0, inj_addr = '0;
  logic [7:0] din = '0;
  logic inj_en = 1'b0;
  logic [12:0] inj_mask = '0;
  logic busy, q_en, err_fixed, err_fatal;
  logic [7:0] dout;

  int n_vec = 0, n_bad = 0;

  always #4 clk = ~clk;

  ecc_byte_sram #(.ADDR_W(AW), .INIT_CYCLES(INITC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .inj_en(inj_en), .inj_addr(inj_addr),
    .inj_mask(inj_mask), .busy(busy), .q_en(q_en), .dout(dout),
    .err_fixed(err_fixed), .err_fatal(err_fatal)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; inj_en = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = a; din = d;
    step();
    chk("R7 write keeps outputs off", {15'd0, q_en}, 16'd0);
    idle();
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [12:0] m);
    inj_en = 1'b1; inj_addr = a; inj_mask = m;
    step();
    inj_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic oe);
    cs_n = 1'b0; we_n = 1'b1; oe_n = oe; addr = a;
    step();
    idle();
  endtask

  initial begin : watchdog
    #(8 * 20000);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    int n;
    int w;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 busy in reset", {15'd0, busy}, 16'd1);
    chk("R11 q_en in reset", {15'd0, q_en}, 16'd0);
    rst_n = 1'b1;

    // R1: write during busy must be dropped, read during busy gives no drive
    cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 4'hC; din = 8'h77;
    step(); n = 1;
    idle();
    cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = 4'hC;
    step(); n++;
    chk("R1 read during busy q_en", {15'd0, q_en}, 16'd0);
    idle();
    while (busy && n < 1000) begin step(); n++; end
    chk("R1 busy length", 16'(n), 16'(INITC));
    step();
    chk("R1 busy stays low", {15'd0, busy}, 16'd0);
    rd(4'hC, 1'b0);
    chk("R1 busy write ignored q_en", {15'd0, q_en}, 16'd1);
    chk("R1 busy write ignored data", {8'd0, dout}, 16'h0000);
    chk("R1 busy write ignored flags", {14'd0, err_fixed, err_fatal}, 16'd0);

    // Table walk: R2 R3 R4 R5 R10
    for (int i = 0; i < NV; i++) begin
      logic [3:0]  a;
      logic [7:0]  d;
      logic [12:0] m;
      {a, d, m} = VEC[i];
      wr(a, d);
      if (m != 0) inject(a, m);
      rd(a, 1'b0);
      w = $countones(m);
      chk($sformatf("R2 vec%0d q_en", i), {15'd0, q_en}, 16'd1);
      if (w == 0) begin
        chk($sformatf("R2 vec%0d data", i), {8'd0, dout}, {8'd0, d});
        chk($sformatf("R2 vec%0d flags", i), {14'd0, err_fixed, err_fatal}, 16'b00);
      end else if (w == 1) begin
        chk($sformatf("R3/R4 R10 vec%0d data", i), {8'd0, dout}, {8'd0, d});
        chk($sformatf("R3 R4 vec%0d flags", i), {14'd0, err_fixed, err_fatal}, 16'b10);
      end else begin
        chk($sformatf("R5 vec%0d flags", i), {14'd0, err_fixed, err_fatal}, 16'b01);
      end
    end

    // R9: no write-back of repair
    rd(4'h1, 1'b0);
    chk("R9 reread data", {8'd0, dout}, 16'h003C);
    chk("R9 reread flags", {14'd0, err_fixed, err_fatal}, 16'b10);

    // R8: output enable off
    rd(4'h0, 1'b1);
    chk("R8 oe off q_en", {15'd0, q_en}, 16'd0);
    chk("R8 oe off bus", {6'd0, dout, err_fixed, err_fatal}, 16'd0);
    rd(4'h5, 1'b1);
    chk("R8 oe off fatal flag", {14'd0, err_fixed, err_fatal}, 16'd0);

    // R6: deselected with oe low
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; addr = 4'h0;
    step();
    chk("R6 deselect q_en", {15'd0, q_en}, 16'd0);
    chk("R6 deselect bus", {6'd0, dout, err_fixed, err_fatal}, 16'd0);
    idle();

    // R10: write wins over same-cycle injection
    cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 4'hA; din = 8'h3D;
    inj_en = 1'b1; inj_addr = 4'hA; inj_mask = 13'h0008;
    step();
    idle();
    rd(4'hA, 1'b0);
    chk("R10 write priority data", {8'd0, dout}, 16'h003D);
    chk("R10 write priority flags", {14'd0, err_fixed, err_fatal}, 16'b00);

    // R7: rewrite after fatal fault clears it
    wr(4'h5, 8'h11);
    rd(4'h5, 1'b0);
    chk("R7 rewrite data", {8'd0, dout}, 16'h0011);
    chk("R7 rewrite flags", {14'd0, err_fixed, err_fatal}, 16'b00);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule